// File: doc/BRIEF.md
# Chip-Enable Write Guard with Post-Reset Battery Check

This block stands between a processor's active-low memory chip-enable and a battery-backed memory. While the system supervisor holds reset, the chip-enable is cut off and the output is driven to its inactive high level, so a failing supply cannot corrupt stored data. When the chip-enable is already asserted at the moment reset arrives, that access may finish. It finishes when the request is released or when a bounded grace period runs out, whichever comes first.

The block also checks the backup battery during the reset-timeout window, which follows power-up or the release of a manual reset. It takes the battery-low flag only during that window. If the flag was seen, the block passes the first memory access after release and swallows the second. Software can detect the missing access and conclude that the battery is weak. When the battery is healthy, every access passes. The enabled path is purely combinational, and all decisions are made from registered history on the system clock.

Top module: `ce_guard_gate`

## Requirements
- R1: `ce_gated_n` is 0 only when `ce_req_n` is 0. With `sup_reset`=0, `mr_clear`=0 and no battery mask, `ce_gated_n` equals `ce_req_n` in the same cycle.
- R2: After `rst_n` is released, reset is treated as already asserted. While `sup_reset`=1 from power-up, `ce_gated_n` stays 1 whatever `ce_req_n` does, and no grace period is granted.
- R3: If `ce_req_n`=0 in the first cycle of `sup_reset`=1 (previous cycle 0), `ce_gated_n` follows `ce_req_n` for at most GRACE_CYC cycles, counting that first cycle. From then until `sup_reset` returns to 0, `ce_gated_n` is 1.
- R4: Once the grace period has ended because `ce_req_n` went to 1, `ce_gated_n` stays 1 for the rest of that reset, even if `ce_req_n` returns to 0.
- R5: If `ce_req_n`=1 when `sup_reset` rises, no grace period is granted and `ce_gated_n` is 1 for the whole reset.
- R6: While `mr_clear`=1, `ce_gated_n` is 1. A clear during a grace period ends that grace period for the rest of the reset.
- R7: `batt_low` is used only in cycles with `sup_tmo`=1. The window result is the OR of `batt_low` over the consecutive `sup_tmo`=1 cycles, latched in the first cycle with `sup_tmo`=0. Outside the window, `batt_low` has no effect on `ce_gated_n`.
- R8: A request pulse is counted as complete in a cycle where `ce_req_n` is 1, was 0 in the previous cycle, and `sup_reset`=0. The count restarts at the end of each window. If the latched result is low-battery, pulse number MASK_PULSE (default 2) is held at 1 for its whole duration. Earlier and later pulses pass.
- R9: If the latched result is not low-battery, every pulse after release passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's state |
| ce_req_n | input | 1 | Active-low chip-enable request from the processor |
| sup_reset | input | 1 | High while the supervisor asserts system reset |
| sup_tmo | input | 1 | High during the reset-timeout window; only meaningful while `sup_reset` is high |
| mr_clear | input | 1 | Qualified manual-reset clear strobe, active high |
| batt_low | input | 1 | High when the backup battery is below its threshold |
| ce_gated_n | output | 1 | Active-low chip-enable to the memory |

## Verification
The bench builds the block with GRACE_CYC=6 and the default MASK_PULSE=2. The short grace period means a request held through a reset runs into the cap within a handful of cycles, so the cut-off edge, the early end through release, and a clear arriving mid-grace are all reached in short episodes. Random reset episodes with windows of varied length and placement exercise the battery latch, including the case where the window closes in the same cycle as reset. Three-pulse trains after release confirm that only the second pulse is suppressed.

// File: rtl/ceg_pkg.sv
// Package: shared levels and edge helpers for the chip-enable guard.
// Assumes: active-low chip-enable convention throughout.
package ceg_pkg;
    localparam logic CE_ACTIVE = 1'b0;
    localparam logic CE_IDLE   = 1'b1;

    // True when a signal went from 0 to 1 between two samples.
    function automatic logic lo_to_hi(input logic prev, input logic cur);
        return !prev && cur;
    endfunction

    // True when a signal went from 1 to 0 between two samples.
    function automatic logic hi_to_lo(input logic prev, input logic cur);
        return prev && !cur;
    endfunction
endpackage

// File: rtl/ceg_grace_timer.sv
// Module: ceg_grace_timer
// Grants a bounded grace period to an access that is in flight when
// reset arrives. It asserts `hold` while the access may still complete.
// Assumes: GRACE_CYC >= 1. The reset history starts as "asserted", so no
// grace is granted at power-up.
module ceg_grace_timer #(
    parameter int GRACE_CYC = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_reset,
    input  logic ce_req_n,
    input  logic mr_clear,
    output logic hold
);
    localparam int GR_W = $clog2(GRACE_CYC + 1);
    localparam logic [GR_W-1:0] LAST_IDX = GR_W'(GRACE_CYC - 1);
    localparam logic [GR_W-1:0] CAP     = GR_W'(GRACE_CYC);

    logic            rst_q;
    logic            grace_q;
    logic [GR_W-1:0] used_cnt;

    // Hold while reset is newly arrived or grace continues, and the request stays active.
    always_comb begin
        hold = sup_reset && (ce_req_n == ceg_pkg::CE_ACTIVE) && !mr_clear
               && (!rst_q || grace_q);
    end

    // Track reset history and count the cycles of grace used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q    <= 1'b1;
            grace_q  <= 1'b0;
            used_cnt <= '0;
        end else begin
            rst_q <= sup_reset;
            if (hold) begin
                used_cnt <= used_cnt + 1'b1;
                grace_q  <= (used_cnt != LAST_IDX);
            end else begin
                used_cnt <= '0;
                grace_q  <= 1'b0;
            end
        end
    end

    // R3
    grace_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= CAP);

    // R3
    grace_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grace_q |-> $past(sup_reset));
endmodule

// File: rtl/ceg_batt_check.sv
// Module: ceg_batt_check
// Samples the battery flag during the reset-timeout window, latches the
// result when the window closes and counts completed request pulses
// after release. It raises `mask` during the configured pulse when the
// battery was low.
// Assumes: the window lies inside reset; MASK_PULSE >= 1.
module ceg_batt_check #(
    parameter int MASK_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_reset,
    input  logic sup_tmo,
    input  logic batt_low,
    input  logic ce_req_n,
    output logic mask
);
    localparam int CNT_W = $clog2(MASK_PULSE + 1);
    localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(MASK_PULSE);
    localparam logic [CNT_W-1:0] HIT_VAL  = CNT_W'(MASK_PULSE - 1);

    logic             tmo_q;
    logic             acc_q;
    logic             low_q;
    logic             req_q;
    logic [CNT_W-1:0] pulse_cnt;
    logic             win_end;
    logic             pulse_done;
    logic             low_eff;
    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W-1:0] cnt_nxt;

    // Window closing, pulse completion and the effective count and result.
    always_comb begin
        win_end    = ceg_pkg::hi_to_lo(tmo_q, sup_tmo);
        pulse_done = ceg_pkg::lo_to_hi(req_q, ce_req_n) && !sup_reset;
        low_eff    = win_end ? acc_q : low_q;
        cnt_base   = win_end ? '0 : pulse_cnt;
        cnt_nxt    = (pulse_done && cnt_base != SAT_VAL) ? cnt_base + 1'b1 : cnt_base;
        mask       = !sup_reset && low_eff && (cnt_base == HIT_VAL);
    end

    // Accumulate the battery flag in the window and latch it at the window's end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= 1'b0;
            acc_q <= 1'b0;
            low_q <= 1'b0;
        end else begin
            tmo_q <= sup_tmo;
            if (sup_tmo) begin
                acc_q <= tmo_q ? (acc_q | batt_low) : batt_low;
            end
            if (win_end) begin
                low_q <= acc_q;
            end
        end
    end

    // Count completed request pulses since the last window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= ceg_pkg::CE_IDLE;
            pulse_cnt <= SAT_VAL;
        end else begin
            req_q     <= ce_req_n;
            pulse_cnt <= cnt_nxt;
        end
    end

    // R8
    pulse_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= SAT_VAL);

    // R7
    acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_tmo |=> $stable(acc_q));
endmodule

// File: rtl/ce_guard_gate.sv
// Module: ce_guard_gate (top)
// Gates an active-low memory chip-enable. The request passes straight
// through while the system runs. It is blocked during reset, apart from
// a bounded grace for an access already in flight, and the configured
// post-release pulse is suppressed when the battery check failed.
// Assumes: sup_tmo is high only while sup_reset is high; inputs are
// synchronous to clk.
module ce_guard_gate #(
    parameter int GRACE_CYC  = 1875,
    parameter int MASK_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_req_n,
    input  logic sup_reset,
    input  logic sup_tmo,
    input  logic mr_clear,
    input  logic batt_low,
    output logic ce_gated_n
);
    logic grace_hold;
    logic batt_mask;

    ceg_grace_timer #(.GRACE_CYC(GRACE_CYC)) u_grace (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_reset (sup_reset),
        .ce_req_n  (ce_req_n),
        .mr_clear  (mr_clear),
        .hold      (grace_hold)
    );

    ceg_batt_check #(.MASK_PULSE(MASK_PULSE)) u_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_reset (sup_reset),
        .sup_tmo   (sup_tmo),
        .batt_low  (batt_low),
        .ce_req_n  (ce_req_n),
        .mask      (batt_mask)
    );

    // Combine the request with every blocking source; blocking drives the idle level.
    always_comb begin
        ce_gated_n = ce_req_n | mr_clear | (sup_reset & ~grace_hold) | batt_mask;
    end

    // R1
    pass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_gated_n == ceg_pkg::CE_ACTIVE) |-> (ce_req_n == ceg_pkg::CE_ACTIVE));

    // R6
    clear_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_clear |-> ce_gated_n);

    // R4
    block_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_reset && $past(sup_reset) && $past(ce_gated_n)) |-> ce_gated_n);
endmodule

// File: tb/ce_guard_gate_tb.sv
// Bench for ce_guard_gate: a cycle model computes the expected output.
// Random reset episodes are mixed with directed corner cases.
module ce_guard_gate_tb;
    localparam int G  = 6;
    localparam int MP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_req_n = 1'b1, sup_reset = 1'b1, sup_tmo = 1'b0, mr_clear = 1'b0, batt_low = 1'b0;
    logic ce_gated_n;

    // Staged inputs, applied at the falling edge.
    logic s_req = 1'b1, s_rst = 1'b1, s_tmo = 1'b0, s_clr = 1'b0, s_bat = 1'b0;

    int n_cmp = 0, n_bad = 0, n_low = 0;

    // Model state.
    logic m_prev_rst, m_gr_on, m_prev_tmo, m_acc, m_low, m_prev_req, m_gr_cut;
    int   m_used, m_pulses;

    ce_guard_gate #(.GRACE_CYC(G), .MASK_PULSE(MP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_req_n(ce_req_n), .sup_reset(sup_reset),
        .sup_tmo(sup_tmo), .mr_clear(mr_clear), .batt_low(batt_low),
        .ce_gated_n(ce_gated_n)
    );

    always #4 clk = ~clk;

    task automatic model_reset();
        m_prev_rst = 1'b1; m_gr_on = 1'b0; m_used = 0; m_gr_cut = 1'b0;
        m_prev_tmo = 1'b0; m_acc = 1'b0; m_low = 1'b0;
        m_prev_req = 1'b1; m_pulses = MP;
    endtask

    function automatic logic model_hold();
        return s_rst && !s_req && !s_clr && (!m_prev_rst || m_gr_on);
    endfunction

    function automatic logic model_mask();
        logic we;
        we = m_prev_tmo && !s_tmo;
        return !s_rst && (we ? m_acc : m_low) && ((we ? 0 : m_pulses) == MP - 1);
    endfunction

    function automatic logic model_out();
        return s_req | s_clr | (s_rst & !model_hold()) | model_mask();
    endfunction

    function automatic string tag_now();
        if (!rst_n)                          return "R2";
        if (s_clr)                           return "R6";
        if (s_bat && !s_tmo)                 return "R7";
        if (s_rst && model_hold())           return "R3";
        if (s_rst && m_gr_cut)               return "R4";
        if (s_rst && !m_prev_rst && s_req)   return "R5";
        if (s_rst)                           return "R2";
        if (model_mask() || m_low)           return "R8";
        if (m_pulses >= 1 && m_pulses < MP)  return "R9";
        return "R1";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic hold, we;
        int   pb;
        hold = model_hold();
        we   = m_prev_tmo && !s_tmo;
        if (hold) begin
            m_used++;
            m_gr_on = (m_used < G);
        end else begin
            if (s_rst && m_prev_rst && (m_gr_on || m_gr_cut)) m_gr_cut = 1'b1;
            else m_gr_cut = 1'b0;
            m_used = 0; m_gr_on = 1'b0;
        end
        if (!s_rst) m_gr_cut = 1'b0;
        if (s_tmo) m_acc = m_prev_tmo ? (m_acc | s_bat) : s_bat;
        if (we) m_low = m_acc;
        pb = we ? 0 : m_pulses;
        if (!m_prev_req && s_req && !s_rst && pb < MP) pb++;
        m_pulses   = pb;
        m_prev_rst = s_rst;
        m_prev_tmo = s_tmo;
        m_prev_req = s_req;
    endtask

    // One clock: apply, compare combinationally, then advance the model.
    task automatic cyc();
        @(negedge clk);
        ce_req_n = s_req; sup_reset = s_rst; sup_tmo = s_tmo;
        mr_clear = s_clr; batt_low = s_bat;
        #1;
        if (ce_gated_n == 1'b0) n_low++;
        check(tag_now(), int'(ce_gated_n), int'(model_out()));
        @(posedge clk);
        if (!rst_n) model_reset();
        else model_step();
    endtask

    task automatic drv(input logic rq, input logic rs, input logic tm,
                       input logic cl, input logic bt, input int n);
        s_req = rq; s_rst = rs; s_tmo = tm; s_clr = cl; s_bat = bt;
        for (int i = 0; i < n; i++) cyc();
    endtask

    // A release sequence: a few reset cycles, then the window, then run.
    task automatic release_with(input logic bat);
        drv(1, 1, 0, 0, 0, 2);
        drv(1, 1, 1, 0, bat, 3);
        drv(1, 0, 0, 0, 0, 2);
    endtask

    // Three pulses of two low cycles; low counts are checked per pulse.
    task automatic pulse_train(input string tag, input int e1, input int e2, input int e3);
        int got[3];
        for (int p = 0; p < 3; p++) begin
            n_low = 0;
            drv(0, 0, 0, 0, 0, 2);
            drv(1, 0, 0, 0, 0, 2);
            got[p] = n_low;
        end
        check(tag, got[0], e1);
        check(tag, got[1], e2);
        check(tag, got[2], e3);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        // R2: reset state, output idle while the block is reset and requested.
        drv(0, 1, 0, 0, 0, 3);
        check("R2", int'(ce_gated_n), 1);
        rst_n = 1'b1;
        // R2: power-up reset blocks the request, with no grace.
        n_low = 0;
        drv(0, 1, 0, 0, 0, 4);
        check("R2", n_low, 0);
        release_with(0);
        // R9: healthy battery, all pulses pass.
        pulse_train("R9", 2, 2, 2);
        // R3: access in flight at reset is capped at G cycles.
        drv(0, 0, 0, 0, 0, 2);
        n_low = 0;
        drv(0, 1, 0, 0, 0, G + 4);
        check("R3", n_low, G);
        release_with(0);
        // R4: grace ends when the request releases, even if it returns.
        drv(0, 0, 0, 0, 0, 1);
        n_low = 0;
        drv(0, 1, 0, 0, 0, 2);
        drv(1, 1, 0, 0, 0, 1);
        drv(0, 1, 0, 0, 0, 4);
        check("R4", n_low, 2);
        release_with(0);
        // R5: request idle at reset rise, no grace afterwards.
        drv(1, 0, 0, 0, 0, 1);
        n_low = 0;
        drv(1, 1, 0, 0, 0, 1);
        drv(0, 1, 0, 0, 0, 4);
        check("R5", n_low, 0);
        release_with(0);
        // R6: clear strobe cuts the grace short.
        drv(0, 0, 0, 0, 0, 1);
        n_low = 0;
        drv(0, 1, 0, 0, 0, 2);
        drv(0, 1, 0, 1, 0, 1);
        drv(0, 1, 0, 0, 0, 4);
        check("R6", n_low, 2);
        release_with(0);
        // R8: low battery in the window masks the second pulse only.
        release_with(1);
        pulse_train("R8", 2, 0, 2);
        // R7: battery flag outside the window is ignored.
        drv(1, 0, 0, 0, 1, 3);
        drv(1, 1, 0, 0, 1, 3);
        drv(1, 1, 1, 0, 0, 3);
        drv(1, 0, 0, 0, 1, 1);
        pulse_train("R7", 2, 2, 2);
        // Random reset episodes.
        for (int ep = 0; ep < 60; ep++) begin
            int n;
            logic rq;
            rq = 1'($urandom % 2);
            n = 3 + int'($urandom % 20);
            for (int i = 0; i < n; i++) begin
                if ($urandom % 3 == 0) rq = !rq;
                drv(rq, 0, 0, ($urandom % 16 == 0), 1'($urandom % 2), 1);
            end
            n = 2 + int'($urandom % 12);
            for (int i = 0; i < n; i++) begin
                if ($urandom % 4 == 0) rq = !rq;
                drv(rq, 1, 0, ($urandom % 12 == 0), 1'($urandom % 2), 1);
            end
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) begin
                if ($urandom % 3 == 0) rq = !rq;
                drv(rq, 1, 1, 0, ($urandom % 4 == 0), 1);
            end
            if ($urandom % 2 == 0) drv(rq, 1, 0, 0, 0, 1);
        end
        drv(1, 0, 0, 0, 0, 2);
        finish_up();
    end
endmodule